// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Shared Prescalers

This peripheral drives four pulse-width-modulated outputs from a single input clock. Four 16-bit prescalers each emit a one-cycle tick every N input clocks, where N is the value programmed for that prescaler. Each channel owns an 8-bit step counter, which advances once per tick of the prescaler its 2-bit selector picks. While the counter is below the channel's 8-bit duty value, the output is high. One period therefore lasts N·256 input clocks, and the output is high for N·duty of them.

Software programs the block over a plain 32-bit register bus with a write strobe, a read strobe and a word address. There are three per-channel control bits: output enable, counter enable and force-high. A new prescaler or duty value takes effect in the cycle after the write, even partway through a period. The output is high at the start of each period, so only one polarity exists.

Top module: `pwm_quad`

## Requirements
- R1: After reset every register reads zero, every output is low and every step counter is zero.
- R2: Register map, by word address. Word 0 holds the output enables in bits 3:0 and the force-high bits in bits 11:8. Word 1 holds the counter enables in bits 3:0. Words 2 to 5 hold prescaler n in bits 15:0. Words 6 to 9 hold channel n's duty in bits 7:0 and its prescaler selector in bits 9:8. A read returns the fields last written, with every other bit zero.
- R3: Read data is registered. It appears the cycle after the read strobe and holds its value while no read strobe is given.
- R4: A read of any word from 10 to 15 returns zero. A write to those words changes no register.
- R5: A prescaler with a value N greater than 0 ticks once every N clocks. A value of 0 stops its ticks.
- R6: A channel whose counter is enabled advances its step counter by one on each tick of its selected prescaler and wraps from 255 to 0. This gives N·duty high clocks in every N·256 clocks: duty 0 is always low and duty 255 is low for one step.
- R7: The selector picks which of the four prescalers feeds the channel's step counter.
- R8: While a channel's counter enable is clear, its step counter is held at zero. The enabled output then stays high if the duty is nonzero and low if the duty is zero.
- R9: While a channel's output enable is clear, its output is low, even when its force-high bit is set.
- R10: While a channel's output enable and force-high bits are both set, its output is high whatever the duty value.
- R11: A new duty, selector or prescaler value affects the output from the next clock on, without waiting for the running period to end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; stores wdata at addr on this edge |
| rd_en | input | 1 | Read strobe; loads rd_data from addr on this edge |
| addr | input | 4 | Word address of the register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pwm_out | output | 4 | Channel outputs, bit n is channel n |

## Verification
The assertions check four rules on every cycle: a disabled output is low, an enabled forced output is high, a held counter is zero, and an enabled counter steps by exactly one on a selected tick. They also check that a stopped prescaler never ticks and that an undefined address reads zero. Only the bench scenarios can show the duty ratio over whole periods, that the selector picks the right prescaler, the readback field masks, and that a mid-period write changes the output at once.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  // word indices of the register map
  localparam int unsigned WORD_CTRL  = 0;
  localparam int unsigned WORD_CNTEN = 1;
  localparam int unsigned WORD_DIV0  = 2;
  // bit position of the first force-high bit in the control word
  localparam int unsigned FORCE_LSB  = 8;
  // bit position of the selector inside a duty word
  localparam int unsigned SEL_LSB    = 8;

  typedef enum logic [2:0] {
    RK_CTRL,
    RK_CNTEN,
    RK_DIV,
    RK_DUTY,
    RK_NONE
  } reg_kind_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_quad_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rd_data,
  output logic [NCH-1:0]              out_en,
  output logic [NCH-1:0]              force_hi,
  output logic [NCH-1:0]              cnt_en,
  output logic [NCH-1:0][DIV_W-1:0]   div_val,
  output logic [NCH-1:0][DUTY_W-1:0]  duty_val,
  output logic [NCH-1:0][SEL_W-1:0]   duty_sel
);
  localparam int unsigned WORD_DUTY0 = WORD_DIV0 + NCH;
  localparam int unsigned WORD_LAST  = WORD_DUTY0 + NCH - 1;

  reg_kind_e               kind;
  logic [$clog2(NCH)-1:0]  idx;
  logic [DATA_W-1:0]       rd_mux;
  logic                    unused_wdata;

  assign unused_wdata = ^wdata;

  // address decode
  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    if (addr == ADDR_W'(WORD_CTRL)) kind = RK_CTRL;
    else if (addr == ADDR_W'(WORD_CNTEN)) kind = RK_CNTEN;
    else begin
      for (int i = 0; i < NCH; i++) begin
        if (addr == ADDR_W'(WORD_DIV0 + i)) begin
          kind = RK_DIV;
          idx  = i[$clog2(NCH)-1:0];
        end
        if (addr == ADDR_W'(WORD_DUTY0 + i)) begin
          kind = RK_DUTY;
          idx  = i[$clog2(NCH)-1:0];
        end
      end
    end
  end

  // register storage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_en   <= '0;
      force_hi <= '0;
      cnt_en   <= '0;
      div_val  <= '0;
      duty_val <= '0;
      duty_sel <= '0;
    end else if (wr_en) begin
      unique case (kind)
        RK_CTRL: begin
          out_en   <= wdata[NCH-1:0];
          force_hi <= wdata[FORCE_LSB +: NCH];
        end
        RK_CNTEN: cnt_en <= wdata[NCH-1:0];
        RK_DIV:   div_val[idx] <= wdata[DIV_W-1:0];
        RK_DUTY: begin
          duty_val[idx] <= wdata[DUTY_W-1:0];
          duty_sel[idx] <= wdata[SEL_LSB +: SEL_W];
        end
        default: ;
      endcase
    end
  end

  // read multiplexer
  always_comb begin
    rd_mux = '0;
    unique case (kind)
      RK_CTRL: begin
        rd_mux[NCH-1:0]          = out_en;
        rd_mux[FORCE_LSB +: NCH] = force_hi;
      end
      RK_CNTEN: rd_mux[NCH-1:0] = cnt_en;
      RK_DIV:   rd_mux[DIV_W-1:0] = div_val[idx];
      RK_DUTY: begin
        rd_mux[DUTY_W-1:0]       = duty_val[idx];
        rd_mux[SEL_LSB +: SEL_W] = duty_sel[idx];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R4: reads outside the map come back as zero
  assert_undef_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr > ADDR_W'(WORD_LAST))) |=> (rd_data == '0));

  // R3: read data only moves on a read strobe
  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] count_q;
  logic             stopped;

  assign stopped = (div_val == '0);
  // compare with >= so that a shrunken divide value takes hold at once
  assign tick = !stopped && (count_q >= div_val - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count_q <= '0;
    else if (stopped || tick)  count_q <= '0;
    else                       count_q <= count_q + DIV_W'(1);
  end

  // R5: a stopped prescaler never ticks
  assert_stopped_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (div_val == '0) |-> !tick);

  // R5: each tick restarts the interval count
  assert_tick_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count_q == '0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int unsigned NDIV   = 4,
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NDIV-1:0]   ticks,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DUTY_W-1:0] duty,
  input  logic              out_en,
  input  logic              force_hi,
  input  logic              cnt_en,
  output logic              pwm
);
  logic [DUTY_W-1:0] step_q;
  logic              step_tick;

  assign step_tick = (32'(sel) < NDIV) ? ticks[sel] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         step_q <= '0;
    else if (!cnt_en)   step_q <= '0;
    else if (step_tick) step_q <= step_q + DUTY_W'(1);
  end

  // output enable wins, then force-high, then the duty compare
  always_comb begin
    if (!out_en)       pwm = 1'b0;
    else if (force_hi) pwm = 1'b1;
    else               pwm = (step_q < duty);
  end

  // R9: disabled output is low
  assert_off_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !pwm);

  // R10: forced output is high
  assert_force_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && force_hi) |-> pwm);

  // R8: held counter sits at zero
  assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (step_q == '0));

  // R6: a selected tick advances the counter by one with wrap
  assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && step_tick) |=> (step_q == $past(step_q) + DUTY_W'(1)));
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned DUTY_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCH-1:0]    pwm_out
);
  localparam int unsigned SEL_W = $clog2(NCH);

  logic [NCH-1:0]             out_en;
  logic [NCH-1:0]             force_hi;
  logic [NCH-1:0]             cnt_en;
  logic [NCH-1:0][DIV_W-1:0]  div_val;
  logic [NCH-1:0][DUTY_W-1:0] duty_val;
  logic [NCH-1:0][SEL_W-1:0]  duty_sel;
  logic [NCH-1:0]             ticks;

  pwm_regs #(
    .NCH(NCH), .DIV_W(DIV_W), .DUTY_W(DUTY_W),
    .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data),
    .out_en(out_en), .force_hi(force_hi), .cnt_en(cnt_en),
    .div_val(div_val), .duty_val(duty_val), .duty_sel(duty_sel)
  );

  for (genvar d = 0; d < NCH; d++) begin : g_pre
    pwm_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .div_val(div_val[d]), .tick(ticks[d])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm_channel #(.NDIV(NCH), .DUTY_W(DUTY_W), .SEL_W(SEL_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .ticks(ticks), .sel(duty_sel[c]),
      .duty(duty_val[c]), .out_en(out_en[c]), .force_hi(force_hi[c]),
      .cnt_en(cnt_en[c]), .pwm(pwm_out[c])
    );
  end
endmodule

// File: tb/sim_pwm_quad.sv
`timescale 1ns/1ps
module sim_pwm_quad;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [3:0]  pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];
  logic rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  pwm_quad u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a[3:0]; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: issue a read and push the expected word to the scoreboard
  task automatic bus_rd(int a, logic [31:0] e, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a[3:0];
    sb_q.push_back('{e, tag});
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: compare read data the cycle after the strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      rd_item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected read data actual=%h expected=none", rd_data);
      end else begin
        it = sb_q.pop_front();
        if (rd_data !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, rd_data, it.exp);
        end
      end
    end
  end

  task automatic measure(int ch, int win, output int hi);
    hi = 0;
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    chk(int'(pwm_out), 0, "R1 outputs low in reset");
    rst_n = 1'b1;
    for (int w = 0; w < 10; w++) bus_rd(w, 32'h0, "R1 reset value");
    chk(int'(pwm_out), 0, "R1 outputs low after reset");

    // R2 field masks on readback
    bus_wr(0, 32'hFFFF_FFFF); bus_rd(0, 32'h0000_0F0F, "R2 control word");
    bus_wr(1, 32'hFFFF_FFFF); bus_rd(1, 32'h0000_000F, "R2 counter enables");
    bus_wr(3, 32'hABCD_1234); bus_rd(3, 32'h0000_1234, "R2 prescaler 1");
    bus_wr(7, 32'hFFFF_F3A5); bus_rd(7, 32'h0000_03A5, "R2 duty word 1");
    for (int w = 0; w < 10; w++) bus_wr(w, 32'h0);
    // R3: data held with no strobe
    repeat (3) @(negedge clk);
    chk(int'(rd_data), 32'h3A5, "R3 read data held");

    // R4 undefined words
    bus_wr(12, 32'hFFFF_FFFF);
    bus_rd(12, 32'h0, "R4 undefined read");
    bus_rd(15, 32'h0, "R4 undefined read top");
    bus_rd(0, 32'h0, "R4 write ignored ctrl");
    bus_rd(6, 32'h0, "R4 write ignored duty");

    // R6 duty ratio on channel 0, prescaler 0
    bus_wr(2, 32'd2); bus_wr(6, 32'd64); bus_wr(1, 32'h1); bus_wr(0, 32'h1);
    measure(0, 512, hi); chk(hi, 128, "R6 duty 64 over N=2");
    bus_wr(2, 32'd1); bus_wr(6, 32'd255);
    measure(0, 256, hi); chk(hi, 255, "R6 duty 255 wrap");
    bus_wr(6, 32'd0);
    measure(0, 256, hi); chk(hi, 0, "R6 duty 0");

    // R5 tick spacing and stopped prescaler
    bus_wr(2, 32'd5); bus_wr(6, 32'd1);
    measure(0, 1280, hi); chk(hi, 5, "R5 one step is N clocks");
    bus_wr(1, 32'h0); bus_wr(2, 32'd0); bus_wr(6, 32'd10); bus_wr(1, 32'h1);
    measure(0, 300, hi); chk(hi, 300, "R5 stopped prescaler");

    // R7 selector on channel 1
    bus_wr(4, 32'd3); bus_wr(5, 32'd7);
    bus_wr(7, (32'd2 << 8) | 32'd1);
    bus_wr(1, 32'h3); bus_wr(0, 32'h3);
    measure(1, 768, hi); chk(hi, 3, "R7 selector 2");
    bus_wr(7, (32'd3 << 8) | 32'd1);
    measure(1, 1792, hi); chk(hi, 7, "R7 selector 3");

    // R8 counter held on channel 2
    bus_wr(0, 32'h7); bus_wr(8, 32'd5);
    measure(2, 100, hi); chk(hi, 100, "R8 held nonzero duty");
    bus_wr(8, 32'd0);
    measure(2, 100, hi); chk(hi, 0, "R8 held zero duty");

    // R9 / R10 on channel 3
    bus_wr(0, 32'h0807);
    measure(3, 50, hi); chk(hi, 0, "R9 disabled beats force");
    bus_wr(0, 32'h080F);
    measure(3, 50, hi); chk(hi, 50, "R10 forced high duty 0");

    // R11 immediate updates on channel 0
    bus_wr(1, 32'h2); bus_wr(6, 32'd0);
    @(negedge clk); chk(int'(pwm_out[0]), 0, "R11 duty 0 low");
    bus_wr(6, 32'd1);
    chk(int'(pwm_out[0]), 1, "R11 duty write at once");
    bus_wr(2, 32'd60000); bus_wr(1, 32'h3);
    repeat (4) @(negedge clk);
    chk(int'(pwm_out[0]), 1, "R11 slow prescaler first step");
    bus_wr(2, 32'd1);
    repeat (2) @(negedge clk);
    chk(int'(pwm_out[0]), 0, "R11 prescaler write mid period");

    repeat (3) @(negedge clk);
    chk(sb_q.size(), 0, "R3 scoreboard drained");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule